// File: doc/BRIEF.md
# Type-C CC Sink Level Detector

This block works out, for a USB Type-C port acting as a sink, which of the two CC lines has a source attached and what current the far-end source advertises on it. It has no analog circuits of its own. It drives a threshold select and a current-source select into an analog front end and reads back one comparator bit per CC line. The current-source select stays at its off code, so the port shows only its pull-down. The block raises the comparator threshold in steps and watches which comparator output drops from set to clear. From the step at which the drop happens, or from the fact that no drop happens, it infers the advertised level.

All timing comes from a slow tick-enable input. One measurement runs after each idle period. A measurement has three phases: a settle wait after every threshold change, a longer quiet wait that lets any traffic on the CC line finish, and the idle period between measurements. Each phase length is a parameter. The two per-line level codes are registered outputs. A one-cycle change pulse reports that a measurement ended with a result that differs from the one held before it. When the enable input is low, the sequencer stays idle and its results do not change.

Top module: `cc_sink_detect`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both level outputs read 0 (Open), the change pulse is low, the threshold select reads 0 and the current-source select reads 0.
- R2: A measurement begins with the threshold select going to 2 after exactly PERIOD_TICKS ticks. Those ticks are counted from the release of reset, from the end of the previous measurement, or from the return of the enable. Cycles with tick low do not count.
- R3: The current-source select always reads code 0 (off).
- R4: The threshold select takes only the codes 0 (idle), 2, 4 and 6. Codes 4 and 6 can only be entered from 2 and 4 respectively. Each threshold is held for SETTLE_TICKS ticks, and the comparators are sampled on the last of those ticks.
- R5: If both comparator bits are clear at threshold 2, both levels become 0 (Open) and the block returns to idle at once.
- R6: If either bit is set at threshold 2, the threshold select stays at 2 for a further WAIT_TICKS ticks before it moves to 4.
- R7: At threshold 4, a line whose bit was set at 2 and is clear at 4 gets level 1 (Default) and the other line gets 0 (Open). CC1 is tested before CC2.
- R8: At threshold 6, the tests run in this order: CC1 set at 4 and clear at 6 gives CC1 = 2 (1.5 A); CC1 set at both gives CC1 = 3 (3.0 A); then the same two tests for CC2. The line not chosen reads 0.
- R9: At the end of a measurement the change pulse is high for exactly one cycle if either level differs from its value before that measurement, and stays low if neither does.
- R10: While the enable is low the threshold select reads 0, both levels hold and no change pulse occurs. If the enable is low on the cycle in which a measurement would finish, the measurement is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Sequencer enable; low holds it idle |
| tick | input | 1 | Time-base enable; all delays count these |
| cc1_cmp | input | 1 | Comparator output for CC1 (set = above threshold) |
| cc2_cmp | input | 1 | Comparator output for CC2 |
| thr_sel | output | 3 | Comparator threshold code: 0, 2, 4 or 6 |
| isrc_sel | output | 2 | Current-source code, held at 0 (off) |
| cc1_lvl | output | 2 | CC1 level: 0 Open, 1 Default, 2 1.5 A, 3 3.0 A |
| cc2_lvl | output | 2 | CC2 level, same encoding |
| chg_pulse | output | 1 | One-cycle pulse when a result changes |

## Verification
Two events can land on the same cycle: the final settle tick that ends a measurement and writes the results, and the enable dropping, which forces the block back to idle. The bench follows the threshold timeline and pulls the enable low just before the edge that would complete a threshold-4 decision for a newly attached Default source. It then expects the threshold select to read 0, both levels to be unchanged and no change pulse. After that it restarts, lets the same measurement run to its end, and expects the new level and a pulse. A bench model of the source derives the comparator bits from the threshold select, so every measurement follows the same path through the thresholds that a real attachment would.

// File: rtl/cc_sink_pkg.sv
package cc_sink_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T2   = 3'd1,
    ST_PDW  = 3'd2,
    ST_T4   = 3'd3,
    ST_T6   = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    LVL_OPEN = 2'd0,
    LVL_DEF  = 2'd1,
    LVL_1A5  = 2'd2,
    LVL_3A0  = 2'd3
  } cc_level_e;

  localparam logic [2:0] THR_IDLE = 3'd0;
  localparam logic [2:0] THR_LOW  = 3'd2;
  localparam logic [2:0] THR_MID  = 3'd4;
  localparam logic [2:0] THR_HIGH = 3'd6;

  localparam logic [1:0] ISRC_OFF = 2'd0;

endpackage

// File: rtl/cc_tick_timer.sv
// Tick counter shared by every wait phase; done flags the tick that
// reaches the terminal value. A clear wins over counting.
module cc_tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] last,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  assign done = tick && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/cc_level_decode.sv
// Decision at the end of a threshold step. prev holds the sample taken at
// the previous step, now is the live comparator pair {cc2, cc1}.
module cc_level_decode
  import cc_sink_pkg::*;
(
  input  seq_state_e stage,
  input  logic [1:0] prev,
  input  logic [1:0] now,
  input  cc_level_e  cur1,
  input  cc_level_e  cur2,
  output logic       fin,
  output cc_level_e  nxt1,
  output cc_level_e  nxt2
);

  logic fall1, fall2, hold1, hold2;

  assign fall1 = prev[0] && !now[0];
  assign fall2 = prev[1] && !now[1];
  assign hold1 = prev[0] &&  now[0];
  assign hold2 = prev[1] &&  now[1];

  always_comb begin
    fin  = 1'b0;
    nxt1 = cur1;
    nxt2 = cur2;
    unique case (stage)
      ST_T2: begin
        if (now == 2'b00) begin
          fin  = 1'b1;
          nxt1 = LVL_OPEN;
          nxt2 = LVL_OPEN;
        end
      end
      ST_T4: begin
        if (fall1) begin
          fin  = 1'b1;
          nxt1 = LVL_DEF;
          nxt2 = LVL_OPEN;
        end else if (fall2) begin
          fin  = 1'b1;
          nxt1 = LVL_OPEN;
          nxt2 = LVL_DEF;
        end
      end
      ST_T6: begin
        // Always the last step; with no match the old results stay.
        fin = 1'b1;
        if (fall1) begin
          nxt1 = LVL_1A5;
          nxt2 = LVL_OPEN;
        end else if (hold1) begin
          nxt1 = LVL_3A0;
          nxt2 = LVL_OPEN;
        end else if (fall2) begin
          nxt1 = LVL_OPEN;
          nxt2 = LVL_1A5;
        end else if (hold2) begin
          nxt1 = LVL_OPEN;
          nxt2 = LVL_3A0;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cc_seq_fsm.sv
// Threshold sequencer: picks the wait length for the timer, steps the
// threshold, keeps the previous sample and owns the result registers.
module cc_seq_fsm
  import cc_sink_pkg::*;
#(
  parameter int SETTLE_TICKS = 18,
  parameter int WAIT_TICKS   = 960,
  parameter int PERIOD_TICKS = 3200,
  parameter int CNT_W        = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             t_done,
  input  logic [1:0]       cmp,
  output logic [CNT_W-1:0] t_last,
  output logic             t_clr,
  output logic [2:0]       thr,
  output logic [1:0]       lvl1,
  output logic [1:0]       lvl2,
  output logic             chg
);

  localparam logic [CNT_W-1:0] LAST_SETTLE = CNT_W'(SETTLE_TICKS - 1);
  localparam logic [CNT_W-1:0] LAST_WAIT   = CNT_W'(WAIT_TICKS - 1);
  localparam logic [CNT_W-1:0] LAST_PERIOD = CNT_W'(PERIOD_TICKS - 1);

  seq_state_e state_q, state_d;
  logic [1:0] samp_q;
  cc_level_e  lvl1_q, lvl2_q, nxt1, nxt2;
  logic       chg_q, thr_fin;
  logic [2:0] thr_q;
  logic       step;

  function automatic logic [2:0] thr_of(seq_state_e s);
    case (s)
      ST_T2, ST_PDW: thr_of = THR_LOW;
      ST_T4:         thr_of = THR_MID;
      ST_T6:         thr_of = THR_HIGH;
      default:       thr_of = THR_IDLE;
    endcase
  endfunction

  cc_level_decode u_dec (
    .stage (state_q),
    .prev  (samp_q),
    .now   (cmp),
    .cur1  (lvl1_q),
    .cur2  (lvl2_q),
    .fin   (thr_fin),
    .nxt1  (nxt1),
    .nxt2  (nxt2)
  );

  assign step  = en && t_done;
  assign t_clr = t_done || !en;

  always_comb begin
    unique case (state_q)
      ST_IDLE: t_last = LAST_PERIOD;
      ST_PDW:  t_last = LAST_WAIT;
      default: t_last = LAST_SETTLE;
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (!en) begin
      state_d = ST_IDLE;
    end else if (t_done) begin
      unique case (state_q)
        ST_IDLE: state_d = ST_T2;
        ST_T2:   state_d = thr_fin ? ST_IDLE : ST_PDW;
        ST_PDW:  state_d = ST_T4;
        ST_T4:   state_d = thr_fin ? ST_IDLE : ST_T6;
        ST_T6:   state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      thr_q   <= THR_IDLE;
      samp_q  <= 2'b00;
      lvl1_q  <= LVL_OPEN;
      lvl2_q  <= LVL_OPEN;
      chg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      thr_q   <= thr_of(state_d);
      chg_q   <= 1'b0;
      if (step && (state_q == ST_T2 || state_q == ST_T4)) begin
        samp_q <= cmp;
      end
      if (step && thr_fin) begin
        lvl1_q <= nxt1;
        lvl2_q <= nxt2;
        chg_q  <= (nxt1 != lvl1_q) || (nxt2 != lvl2_q);
      end
    end
  end

  assign thr  = thr_q;
  assign lvl1 = lvl1_q;
  assign lvl2 = lvl2_q;
  assign chg  = chg_q;

endmodule

// File: rtl/cc_sink_detect.sv
module cc_sink_detect
  import cc_sink_pkg::*;
#(
  parameter int SETTLE_TICKS = 18,
  parameter int WAIT_TICKS   = 960,
  parameter int PERIOD_TICKS = 3200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tick,
  input  logic       cc1_cmp,
  input  logic       cc2_cmp,
  output logic [2:0] thr_sel,
  output logic [1:0] isrc_sel,
  output logic [1:0] cc1_lvl,
  output logic [1:0] cc2_lvl,
  output logic       chg_pulse
);

  localparam int MAX_A = (SETTLE_TICKS > WAIT_TICKS) ? SETTLE_TICKS : WAIT_TICKS;
  localparam int MAX_T = (MAX_A > PERIOD_TICKS) ? MAX_A : PERIOD_TICKS;
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic [CNT_W-1:0] t_last;
  logic             t_clr, t_done;

  cc_tick_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .clr  (t_clr),
    .tick (tick),
    .last (t_last),
    .done (t_done)
  );

  cc_seq_fsm #(
    .SETTLE_TICKS (SETTLE_TICKS),
    .WAIT_TICKS   (WAIT_TICKS),
    .PERIOD_TICKS (PERIOD_TICKS),
    .CNT_W        (CNT_W)
  ) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .t_done (t_done),
    .cmp    ({cc2_cmp, cc1_cmp}),
    .t_last (t_last),
    .t_clr  (t_clr),
    .thr    (thr_sel),
    .lvl1   (cc1_lvl),
    .lvl2   (cc2_lvl),
    .chg    (chg_pulse)
  );

  assign isrc_sel = ISRC_OFF;

endmodule

// File: rtl/cc_sink_detect_chk.sv
module cc_sink_detect_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [2:0] thr_sel,
  input logic [1:0] cc1_lvl,
  input logic [1:0] cc2_lvl,
  input logic       chg_pulse
);

  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= 1'b1;
  end

  // R4
  thr_mid_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q && thr_sel == 3'd4) |-> ($past(thr_sel) == 3'd2 || $past(thr_sel) == 3'd4));

  // R4
  thr_high_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q && thr_sel == 3'd6) |-> ($past(thr_sel) == 3'd4 || $past(thr_sel) == 3'd6));

  // R4
  thr_code_chk: assert property (@(posedge clk) disable iff (rst)
    !thr_sel[0]);

  // R9
  chg_single_chk: assert property (@(posedge clk) disable iff (rst)
    chg_pulse |=> !chg_pulse);

  // R9
  chg_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q && chg_pulse) |-> (cc1_lvl != $past(cc1_lvl) || cc2_lvl != $past(cc2_lvl)));

  // R9
  lvl_move_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q && (cc1_lvl != $past(cc1_lvl) || cc2_lvl != $past(cc2_lvl))) |-> chg_pulse);

  // R10
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(cc1_lvl) && $stable(cc2_lvl) && !chg_pulse && thr_sel == 3'd0));

endmodule

bind cc_sink_detect cc_sink_detect_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .thr_sel   (thr_sel),
  .cc1_lvl   (cc1_lvl),
  .cc2_lvl   (cc2_lvl),
  .chg_pulse (chg_pulse)
);

// File: tb/cc_sink_detect_tb.sv
module cc_sink_detect_tb;

  localparam int S = 3;
  localparam int W = 5;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b1;
  logic       tick = 1'b1;
  logic       cc1_cmp, cc2_cmp;
  logic [2:0] thr_sel;
  logic [1:0] isrc_sel, cc1_lvl, cc2_lvl;
  logic       chg_pulse;

  // Far-end source model: 0 open, 1 default, 2 1.5 A, 3 3.0 A
  logic [1:0] src1 = 2'd0;
  logic [1:0] src2 = 2'd0;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  function automatic logic above(logic [1:0] s, logic [2:0] t);
    return (t == 3'd2 && s >= 2'd1) || (t == 3'd4 && s >= 2'd2) ||
           (t == 3'd6 && s == 2'd3);
  endfunction

  assign cc1_cmp = above(src1, thr_sel);
  assign cc2_cmp = above(src2, thr_sel);

  cc_sink_detect #(.SETTLE_TICKS(S), .WAIT_TICKS(W), .PERIOD_TICKS(P)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .tick      (tick),
    .cc1_cmp   (cc1_cmp),
    .cc2_cmp   (cc2_cmp),
    .thr_sel   (thr_sel),
    .isrc_sel  (isrc_sel),
    .cc1_lvl   (cc1_lvl),
    .cc2_lvl   (cc2_lvl),
    .chg_pulse (chg_pulse)
  );

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_start();
    for (int i = 0; i < 200; i++) begin
      if (thr_sel == 3'd2) break;
      step(1);
    end
    chk("R2", "thr at start", int'(thr_sel), 2);
  endtask

  // One full measurement for the given source, with the threshold timeline checked.
  task automatic measure(string req, logic [1:0] s1, logic [1:0] s2,
                         int e1, int e2, int echg);
    src1 = s1;
    src2 = s2;
    wait_start();
    if (s1 == 0 && s2 == 0) begin
      step(S - 1);
      chk("R5", "thr settle", int'(thr_sel), 2);
      step(1);
    end else begin
      step(S + W - 1);
      chk("R6", "thr before mid", int'(thr_sel), 2);
      step(1);
      chk("R6", "thr mid", int'(thr_sel), 4);
      if (s1 == 1 || s2 == 1) begin
        step(S);
      end else begin
        step(S - 1);
        chk("R4", "thr mid held", int'(thr_sel), 4);
        step(1);
        chk("R4", "thr high", int'(thr_sel), 6);
        step(S);
      end
    end
    chk(req, "cc1_lvl", int'(cc1_lvl), e1);
    chk(req, "cc2_lvl", int'(cc2_lvl), e2);
    chk("R9", "chg_pulse", int'(chg_pulse), echg);
    chk("R4", "thr back idle", int'(thr_sel), 0);
    chk("R3", "isrc_sel", int'(isrc_sel), 0);
    step(1);
    chk("R9", "chg one cycle", int'(chg_pulse), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(3);
    chk("R1", "cc1_lvl", int'(cc1_lvl), 0);
    chk("R1", "cc2_lvl", int'(cc2_lvl), 0);
    chk("R1", "chg_pulse", int'(chg_pulse), 0);
    chk("R1", "thr_sel", int'(thr_sel), 0);
    chk("R3", "isrc_sel", int'(isrc_sel), 0);
    rst = 1'b0;
  endtask

  task automatic t_first_period();
    step(P - 1);
    chk("R2", "thr before first period", int'(thr_sel), 0);
    step(1);
    chk("R2", "thr after first period", int'(thr_sel), 2);
    step(S - 1);
    chk("R4", "thr held for settle", int'(thr_sel), 2);
    step(1);
    chk("R5", "open ends at once", int'(thr_sel), 0);
    chk("R5", "cc1 open", int'(cc1_lvl), 0);
    chk("R9", "no pulse open->open", int'(chg_pulse), 0);
    step(P - 1);
    chk("R2", "thr before next period", int'(thr_sel), 0);
    step(1);
    chk("R2", "next start", int'(thr_sel), 2);
  endtask

  task automatic t_levels();
    measure("R7", 2'd1, 2'd0, 1, 0, 1);
    measure("R9", 2'd1, 2'd0, 1, 0, 0);
    measure("R7", 2'd0, 2'd1, 0, 1, 1);
    measure("R8", 2'd2, 2'd0, 2, 0, 1);
    measure("R8", 2'd0, 2'd3, 0, 3, 1);
    measure("R8", 2'd0, 2'd2, 0, 2, 1);
    measure("R8", 2'd3, 2'd0, 3, 0, 1);
    measure("R7", 2'd1, 2'd1, 1, 0, 1);   // CC1 tested first
    measure("R8", 2'd3, 2'd2, 3, 0, 1);   // CC1 held beats CC2 falling
    measure("R8", 2'd2, 2'd3, 2, 0, 1);
    measure("R5", 2'd0, 2'd0, 0, 0, 1);
  endtask

  task automatic t_enable_collision();
    src1 = 2'd1;
    src2 = 2'd0;
    wait_start();
    step(S + W);
    chk("R10", "thr mid before drop", int'(thr_sel), 4);
    step(S - 1);
    en = 1'b0;   // low on the cycle the decision would land
    step(1);
    chk("R10", "thr idle", int'(thr_sel), 0);
    chk("R10", "cc1 held", int'(cc1_lvl), 0);
    chk("R10", "no pulse", int'(chg_pulse), 0);
    step(4 * P);
    chk("R10", "thr idle while off", int'(thr_sel), 0);
    chk("R10", "cc1 held while off", int'(cc1_lvl), 0);
    en = 1'b1;
    step(P - 1);
    chk("R2", "thr before restart", int'(thr_sel), 0);
    step(1);
    chk("R2", "restart", int'(thr_sel), 2);
    step(S + W);
    step(S);
    chk("R7", "cc1 after restart", int'(cc1_lvl), 1);
    chk("R9", "pulse after restart", int'(chg_pulse), 1);
  endtask

  task automatic t_tick_gate();
    tick = 1'b0;
    step(5 * P);
    chk("R2", "no start without ticks", int'(thr_sel), 0);
    tick = 1'b1;
    step(P - 1);
    chk("R2", "thr before gated period", int'(thr_sel), 0);
    step(1);
    chk("R2", "start after gated period", int'(thr_sel), 2);
  endtask

  initial begin
    step(1);
    t_reset();
    t_first_period();
    t_levels();
    t_enable_collision();
    t_tick_gate();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule